// File: doc/BRIEF.md
# Interrupt Entry and Stack Sequencer

This block is the interrupt and stack section of an 8-bit processor core. It owns the 8-bit stack pointer and decides between a non-maskable request and a maskable request. When a request is taken, it saves the running context over a byte-wide memory port, fetches the handler address and hands the new program counter back to the core. On a return command it pulls the saved context back off the stack. Instruction decode and arithmetic live elsewhere. The core presents its current program counter and status byte, pulses `insn_done` at each instruction boundary and raises `rti_cmd` to request a return.

The sequencer is a single state machine. `S_IDLE` moves to `S_PUSH_PCH` when a request is taken at a boundary, and to `S_PULL_STAT` when a return command is seen. The entry path then steps through `S_PUSH_PCH → S_PUSH_PCL → S_PUSH_STAT → S_VEC_LO → S_VEC_HI → S_VEC_DONE → S_IDLE`, one state per cycle. The return path steps through `S_PULL_STAT → S_PULL_PCL → S_PULL_PCH → S_RET_DONE → S_IDLE`. Memory reads are synchronous: data for a read issued in one cycle is presented on `mem_rdata` in the next cycle.

Top module: `intr_stack_seq`

## Requirements
- R1: After reset `busy`, `mem_we`, `mem_re`, `pc_load` and `status_load` are 0 and `sp_out` equals 0xFD.
- R2: An entry performs three writes at address {0x01, sp}, decrementing sp after each, in this order: PC[15:8], PC[7:0], then the status byte. `sp_out` ends 3 lower.
- R3: An entry reads the handler low byte at the vector base and the high byte at base+1. `pc_load` is high with `pc_out` = {high, low} exactly 6 cycles after the boundary cycle. In that same cycle `status_load` is high with `status_out` = saved status with bit 2 set.
- R4: If both are eligible at a boundary, the non-maskable request is taken. Its vector base is 0xFFFA; the maskable request uses 0xFFFE.
- R5: A rising edge on `nmi_line` is latched until it is serviced. A line held high does not raise a second request.
- R6: `irq_line` is level-sensitive. It is ignored while `status_in` bit 2 is 1.
- R7: Requests are taken only on an `insn_done` pulse while idle. An `insn_done` pulse during a sequence has no effect, and a request arriving meanwhile stays pending.
- R8: A return first increments sp and then reads, three times: status, then PC low, then PC high. `pc_load` and `status_load` are high 4 cycles after the command cycle with the restored values, and `sp_out` ends 3 higher.
- R9: The stack pointer wraps modulo 256 in both directions.
- R10: When `rti_cmd` and an eligible request meet in the same idle cycle, the return runs first and the request stays pending.
- R11: `mem_we` and `mem_re` are never high together, and `mem_rdata` is taken one cycle after its read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe |
| rti_cmd | input | 1 | Return-from-interrupt command |
| nmi_line | input | 1 | Non-maskable request, edge-sensitive |
| irq_line | input | 1 | Maskable request, level-sensitive |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status byte (bit 2 = interrupt disable) |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Load strobe for `pc_out` |
| status_out | output | 8 | New status byte |
| status_load | output | 1 | Load strobe for `status_out` |
| busy | output | 1 | Sequence in progress |
| sp_out | output | 8 | Current stack pointer |

## Verification
Two same-cycle conflicts matter. The first is a latched non-maskable request and a level maskable request meeting at one boundary. The second is a return command arriving in the same cycle as a pending request. The bench provokes both directly, and also lets random stimulus raise the request lines and the return command together. For the first case it checks which vector is fetched. For the second it checks that the return completes in 4 cycles and that the next boundary takes the waiting request. A further case raises a new edge together with an `insn_done` pulse in the middle of an entry, and it is judged by the pointer moving only 3 places and by the next boundary taking the new request.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_PCH,
        S_PUSH_PCL,
        S_PUSH_STAT,
        S_VEC_LO,
        S_VEC_HI,
        S_VEC_DONE,
        S_PULL_STAT,
        S_PULL_PCL,
        S_PULL_PCH,
        S_RET_DONE
    } seq_state_t;
endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_line,
    input  logic irq_line,
    input  logic irq_mask,
    input  logic sample,
    output logic take_nmi,
    output logic take_irq
);
    logic nmi_prev;
    logic nmi_pend;
    logic nmi_rise;

    assign nmi_rise = nmi_line & ~nmi_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_line;
            if (nmi_rise)
                nmi_pend <= 1'b1;
            else if (take_nmi)
                nmi_pend <= 1'b0;
        end
    end

    assign take_nmi = sample & nmi_pend;
    assign take_irq = sample & ~nmi_pend & irq_line & ~irq_mask;

    // R5
    nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_rise |=> nmi_pend);
    // R5
    nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !take_nmi) |=> nmi_pend);
    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !take_irq);
endmodule

// File: rtl/intr_sp_unit.sv
module intr_sp_unit #(
    parameter int          SP_W    = 8,
    parameter logic [7:0]  SP_INIT = 8'hFD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pull,
    output logic [SP_W-1:0] sp_q,
    output logic [SP_W-1:0] sp_up
);
    localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= SP_W'(SP_INIT);
        else if (push)
            sp_q <= sp_q - SP_ONE;
        else if (pull)
            sp_q <= sp_q + SP_ONE;
    end

    assign sp_up = sp_q + SP_ONE;

    // R11
    push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pull));
endmodule

// File: rtl/intr_stack_seq.sv
module intr_stack_seq
    import intr_seq_pkg::*;
#(
    parameter int           I_BIT      = 2,
    parameter logic [7:0]   SP_INIT    = 8'hFD,
    parameter logic [7:0]   STACK_PAGE = 8'h01,
    parameter logic [15:0]  NMI_VEC    = 16'hFFFA,
    parameter logic [15:0]  IRQ_VEC    = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_done,
    input  logic        rti_cmd,
    input  logic        nmi_line,
    input  logic        irq_line,
    input  logic [15:0] pc_in,
    input  logic [7:0]  status_in,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] pc_out,
    output logic        pc_load,
    output logic [7:0]  status_out,
    output logic        status_load,
    output logic        busy,
    output logic [7:0]  sp_out
);
    localparam int          DW     = 8;
    localparam logic [DW-1:0] I_MASK = DW'(1) << I_BIT;

    seq_state_t state_q, state_d;

    logic          take_nmi, take_irq, sample;
    logic          push, pull;
    logic [DW-1:0] sp_q, sp_up;
    logic [15:0]   pc_sv;
    logic [DW-1:0] stat_sv, lo_byte;
    logic          use_nmi;
    logic [15:0]   vec_base;

    assign sample   = (state_q == S_IDLE) & insn_done & ~rti_cmd;
    assign vec_base = use_nmi ? NMI_VEC : IRQ_VEC;

    intr_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_line (nmi_line),
        .irq_line (irq_line),
        .irq_mask (status_in[I_BIT]),
        .sample   (sample),
        .take_nmi (take_nmi),
        .take_irq (take_irq)
    );

    intr_sp_unit #(.SP_W(DW), .SP_INIT(SP_INIT)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pull  (pull),
        .sp_q  (sp_q),
        .sp_up (sp_up)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (rti_cmd)                    state_d = S_PULL_STAT;
                else if (take_nmi || take_irq)  state_d = S_PUSH_PCH;
            end
            S_PUSH_PCH:  state_d = S_PUSH_PCL;
            S_PUSH_PCL:  state_d = S_PUSH_STAT;
            S_PUSH_STAT: state_d = S_VEC_LO;
            S_VEC_LO:    state_d = S_VEC_HI;
            S_VEC_HI:    state_d = S_VEC_DONE;
            S_VEC_DONE:  state_d = S_IDLE;
            S_PULL_STAT: state_d = S_PULL_PCL;
            S_PULL_PCL:  state_d = S_PULL_PCH;
            S_PULL_PCH:  state_d = S_RET_DONE;
            S_RET_DONE:  state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // Context and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_sv   <= '0;
            stat_sv <= '0;
            lo_byte <= '0;
            use_nmi <= 1'b0;
        end else begin
            if (state_q == S_IDLE && !rti_cmd && (take_nmi || take_irq)) begin
                pc_sv   <= pc_in;
                stat_sv <= status_in;
                use_nmi <= take_nmi;
            end
            if (state_q == S_VEC_HI || state_q == S_PULL_PCH)
                lo_byte <= mem_rdata;
            if (state_q == S_PULL_PCL)
                stat_sv <= mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        mem_addr    = '0;
        mem_we      = 1'b0;
        mem_wdata   = '0;
        mem_re      = 1'b0;
        pc_out      = '0;
        pc_load     = 1'b0;
        status_out  = '0;
        status_load = 1'b0;
        push        = 1'b0;
        pull        = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PUSH_PCH: begin
                mem_addr = {STACK_PAGE, sp_q}; mem_we = 1'b1; push = 1'b1;
                mem_wdata = pc_sv[15:8];
            end
            S_PUSH_PCL: begin
                mem_addr = {STACK_PAGE, sp_q}; mem_we = 1'b1; push = 1'b1;
                mem_wdata = pc_sv[7:0];
            end
            S_PUSH_STAT: begin
                mem_addr = {STACK_PAGE, sp_q}; mem_we = 1'b1; push = 1'b1;
                mem_wdata = stat_sv;
            end
            S_VEC_LO: begin
                mem_addr = vec_base; mem_re = 1'b1;
            end
            S_VEC_HI: begin
                mem_addr = vec_base | 16'd1; mem_re = 1'b1;
            end
            S_VEC_DONE: begin
                pc_out = {mem_rdata, lo_byte}; pc_load = 1'b1;
                status_out = stat_sv | I_MASK; status_load = 1'b1;
            end
            S_PULL_STAT, S_PULL_PCL, S_PULL_PCH: begin
                mem_addr = {STACK_PAGE, sp_up}; mem_re = 1'b1; pull = 1'b1;
            end
            S_RET_DONE: begin
                pc_out = {mem_rdata, lo_byte}; pc_load = 1'b1;
                status_out = stat_sv; status_load = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy   = (state_q != S_IDLE);
    assign sp_out = sp_q;

    // R11
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    // R2
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out == 8'($past(sp_out) - 8'd1)));
    // R2
    push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == STACK_PAGE));
    // R3
    load_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(mem_re));
    // R7
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done || rti_cmd));
endmodule

// File: tb/intr_stack_seq_test.sv
`timescale 1ns/1ps
module intr_stack_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0, rti_cmd = 1'b0, nmi_line = 1'b0, irq_line = 1'b0;
    logic [15:0] pc_m = 16'h8000;
    logic [7:0]  st_m = 8'h00;
    logic [15:0] mem_addr, pc_out;
    logic        mem_we, mem_re, pc_load, status_load, busy;
    logic [7:0]  mem_wdata, mem_rdata, status_out, sp_out;

    always #2.5 clk = ~clk;

    intr_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rti_cmd(rti_cmd),
        .nmi_line(nmi_line), .irq_line(irq_line), .pc_in(pc_m), .status_in(st_m),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .pc_out(pc_out), .pc_load(pc_load),
        .status_out(status_out), .status_load(status_load), .busy(busy), .sp_out(sp_out)
    );

    // Memory model: stack page plus four vector bytes
    logic [7:0] stk_mem [256];
    logic [7:0] vec_b [4];
    function automatic logic [7:0] rd_byte(input logic [15:0] a);
        if (a[15:8] == 8'h01) return stk_mem[a[7:0]];
        case (a)
            16'hFFFA: return vec_b[0];
            16'hFFFB: return vec_b[1];
            16'hFFFE: return vec_b[2];
            16'hFFFF: return vec_b[3];
            default:  return 8'hEE;
        endcase
    endfunction
    always @(posedge clk) begin
        if (mem_we && mem_addr[15:8] == 8'h01) stk_mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= rd_byte(mem_addr);
    end

    int  n_chk = 0, n_fail = 0;
    bit  reported = 0;
    logic [7:0] exp_stack [256];
    logic [7:0] sp_m = 8'hFD;
    int  depth = 0;
    bit  nmi_pend_m = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        end
    endtask

    task automatic set_nmi(input logic v);
        if (v && !nmi_line) nmi_pend_m = 1;
        nmi_line = v;
        @(negedge clk);
    endtask

    function automatic logic [15:0] vec_of(input bit nmi);
        return nmi ? {vec_b[1], vec_b[0]} : {vec_b[3], vec_b[2]};
    endfunction

    // One boundary (or return) from a negedge; poke adds an edge and strobe mid-sequence
    task automatic run_case(input bit rti, input bit poke);
        int kind, lat, exp_lat;
        logic [15:0] pco, exp_pc;
        logic [7:0] sto, exp_st, sp0;
        logic stl;
        bit both;
        sp0 = sp_m; lat = 0; both = 0; pco = 0; sto = 0; stl = 0;
        exp_pc = 0; exp_st = 0; exp_lat = 0;
        if (rti) kind = 3;
        else if (nmi_pend_m) kind = 1;
        else if (irq_line && !st_m[2]) kind = 2;
        else kind = 0;
        if (kind == 1) nmi_pend_m = 0;
        if (kind == 1 || kind == 2) begin
            exp_stack[sp0] = pc_m[15:8];
            exp_stack[8'(sp0 - 8'd1)] = pc_m[7:0];
            exp_stack[8'(sp0 - 8'd2)] = st_m;
            exp_pc = vec_of(kind == 1); exp_st = st_m | 8'h04; exp_lat = 6;
            sp_m = 8'(sp0 - 8'd3); depth++;
        end else if (kind == 3) begin
            exp_st = exp_stack[8'(sp0 + 8'd1)];
            exp_pc = {exp_stack[8'(sp0 + 8'd3)], exp_stack[8'(sp0 + 8'd2)]};
            exp_lat = 4; sp_m = 8'(sp0 + 8'd3); depth--;
        end
        insn_done = 1'b1; rti_cmd = rti;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            insn_done = 1'b0; rti_cmd = 1'b0;
            if (poke && k == 2) begin
                if (!nmi_line) nmi_pend_m = 1;
                nmi_line = 1'b1; insn_done = 1'b1;
            end
            if (mem_we && mem_re) both = 1;
            if (pc_load && lat == 0) begin
                lat = k; pco = pc_out; sto = status_out; stl = status_load;
            end
        end
        chk(!both, "R11 rw exclusive", both, 0);
        chk(lat == exp_lat, kind == 3 ? "R8 return latency" : "R3/R4/R6 entry latency", lat, exp_lat);
        if (kind != 0) begin
            chk(pco == exp_pc, kind == 3 ? "R8 restored pc" : (kind == 1 ? "R4 nmi vector" : "R3 irq vector"), pco, exp_pc);
            chk(stl && sto == exp_st, kind == 3 ? "R8 restored status" : "R3 entry status", sto, exp_st);
        end
        chk(sp_out == sp_m, "R9 sp tracking (R2/R8)", sp_out, sp_m);
        chk(!busy, "R7 back to idle", busy, 0);
        if (kind == 1 || kind == 2)
            for (int j = 0; j < 3; j++)
                chk(stk_mem[8'(sp0 - 8'(j))] == exp_stack[8'(sp0 - 8'(j))], "R2 push byte",
                    stk_mem[8'(sp0 - 8'(j))], exp_stack[8'(sp0 - 8'(j))]);
        if (kind != 0) begin
            pc_m = pco; st_m = sto;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        vec_b[0] = 8'h34; vec_b[1] = 8'h92; vec_b[2] = 8'h78; vec_b[3] = 8'hC5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !mem_we && !mem_re && !pc_load && !status_load, "R1 quiet after reset", busy, 0);
        chk(sp_out == 8'hFD, "R1 sp reset", sp_out, 8'hFD);

        // R6 masked irq, then unmasked
        irq_line = 1'b1; st_m = 8'h24; pc_m = 16'h1234;
        run_case(0, 0);
        st_m = 8'h20;
        run_case(0, 0);
        // R4 both eligible: nmi wins
        st_m = 8'h00; pc_m = 16'hABCD;
        set_nmi(1'b1);
        run_case(0, 0);
        // R5 nmi held high: no second request
        st_m = 8'h04; irq_line = 1'b0;
        run_case(0, 0);
        // R10 return and pending nmi together
        set_nmi(1'b0); set_nmi(1'b1);
        run_case(1, 0);
        st_m = 8'h04;
        run_case(0, 0);
        // R7 strobe and new edge during an entry
        set_nmi(1'b0);
        irq_line = 1'b1; st_m = 8'h00; pc_m = 16'h4321;
        run_case(0, 1);
        st_m = 8'h04;
        run_case(0, 0);
        irq_line = 1'b0;
        while (depth > 0) run_case(1, 0);

        // R9 wrap below zero and back
        for (int n = 0; n < 90; n++) begin
            set_nmi(1'b0); set_nmi(1'b1);
            pc_m = 16'($urandom);
            run_case(0, 0);
        end
        chk(sp_out == 8'hEF, "R9 wrap down", sp_out, 8'hEF);
        while (depth > 0) run_case(1, 0);
        chk(sp_out == 8'hFD, "R9 wrap up", sp_out, 8'hFD);

        // Random mix
        for (int n = 0; n < 250; n++) begin
            irq_line = 1'($urandom);
            st_m = 8'($urandom);
            pc_m = 16'($urandom);
            if ($urandom % 3 == 0) begin set_nmi(1'b0); set_nmi(1'b1); end
            run_case(depth > 0 && ($urandom % 3 == 0), 0);
        end
        report();
        $finish;
    end
endmodule